// File: doc/BRIEF.md
# Slope-Compensated Peak-Current Threshold Generator

This block computes the digital code for the reference DAC that sets the peak-current trip point of a current-mode switching regulator. The voltage-loop controller supplies a desired current set point. The block subtracts a sawtooth that grows by a programmable slope on every clock and restarts on each PWM period-start strobe. The threshold therefore falls across each switching period, which keeps the inner current loop stable when the duty cycle is above one half.

The set point and the slope are captured only on the period-start strobe. A change made by the controller between pulses therefore never moves the threshold part-way through a pulse. The difference is clamped to the DAC range and never wraps. When the enable input is low, the captured set point goes to the DAC without compensation.

Top module: `slope_ref_gen`

## Requirements
- R1: While reset is asserted and after its release with no strobe yet seen, `dac_code` is 0.
- R2: The 12-bit unsigned `set_point` is captured only in a clock where `period_start` is 1. Changes at other times do not reach `dac_code` until the next strobe.
- R3: A strobe restarts the ramp at zero. One clock after the strobe edge, `dac_code` equals the newly captured set point, clamped to 1023.
- R4: With `en` high, after the n-th rising edge following the strobe edge (n ≥ 1), `dac_code` = clamp(S − (n−1)·M). S is the captured set point, M is the captured 8-bit unsigned slope, and clamp limits to the range 0 to 1023.
- R5: A captured slope of 0 holds `dac_code` at the clamped set point for the whole period.
- R6: When the ramp exceeds the set point, `dac_code` is 0 and stays 0 for the rest of the period, with no wrap to large values.
- R7: A set point above 1023 gives `dac_code` = 1023 while the difference stays above 1023.
- R8: With `en` low, `dac_code` equals the captured set point clamped to 1023, and the ramp is not applied.
- R9: The `slope` input is captured only at the strobe. Changes in the middle of a period do not alter that period's ramp.
- R10: The internal ramp saturates at its maximum (8191) instead of wrapping. A long period therefore keeps `dac_code` at 0 indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | 1 applies the ramp, 0 passes the set point through |
| period_start | input | 1 | One-clock pulse at the start of each PWM period |
| set_point | input | 12 | Desired peak current from the voltage loop (unsigned) |
| slope | input | 8 | Ramp increment per clock (unsigned) |
| dac_code | output | 10 | Clamped reference DAC code |

## Verification
The ramp arithmetic is driven with a table of set point, slope and edge-count triples. The table covers a mid-range linear fall, a zero slope, a set point above the DAC range, and a steep slope that crosses zero. Together these separate correct subtraction from off-by-one timing, missing clamps and wrap-around. Directed sequences change `set_point` and `slope` part-way through a period to show that both are captured only at the strobe. Further sequences drop `en` to show the bypass, and run a long period with the maximum slope to show the saturating ramp against a wrapping one.

// File: rtl/slope_ref_pkg.sv
// Shared types for the slope-compensated threshold generator.
package slope_ref_pkg;

    // Selects how the output stage forms the DAC code.
    typedef enum logic {
        OUT_BYPASS = 1'b0,   // captured set point, no ramp
        OUT_COMP   = 1'b1    // set point minus ramp
    } out_mode_e;

endpackage

// File: rtl/sr_shadow_reg.sv
// Shadow register: holds a value that may only change on a load pulse.
// Assumes load is a single-clock strobe aligned to the PWM period start.
module sr_shadow_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture d only on the strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sr_ramp_acc.sv
// Compensation ramp: restarts at zero on the period strobe and then adds
// the captured slope every clock, saturating at all-ones instead of wrapping.
// Assumes SL_W <= RAMP_W.
module sr_ramp_acc #(
    parameter int SL_W   = 8,
    parameter int RAMP_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [SL_W-1:0]   step,
    output logic [RAMP_W-1:0] ramp
);

    localparam int SUM_W = RAMP_W + 1;

    logic [SUM_W-1:0] sum;

    // Next ramp value with one carry bit to detect overflow.
    always_comb begin
        sum = {1'b0, ramp} + {{(SUM_W - SL_W){1'b0}}, step};
    end

    // Restart, saturate on carry, else accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp <= '0;
        end else if (restart) begin
            ramp <= '0;
        end else if (sum[RAMP_W]) begin
            ramp <= '1;
        end else begin
            ramp <= sum[RAMP_W-1:0];
        end
    end

endmodule

// File: rtl/sr_out_stage.sv
// Output stage: subtracts the ramp from the captured set point (or passes
// the set point when disabled), clamps to the DAC range and registers it.
// Assumes both operands are unsigned; the subtraction is done signed.
module sr_out_stage
    import slope_ref_pkg::*;
#(
    parameter int SP_W   = 12,
    parameter int RAMP_W = 13,
    parameter int DAC_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SP_W-1:0]   sp,
    input  logic [RAMP_W-1:0] ramp,
    output logic [DAC_W-1:0]  dac
);

    localparam int DIFF_W = ((SP_W > RAMP_W) ? SP_W : RAMP_W) + 2;
    localparam logic signed [DIFF_W-1:0] DAC_TOP = DIFF_W'((1 << DAC_W) - 1);

    out_mode_e                 mode;
    logic signed [DIFF_W-1:0]  sp_ext;
    logic signed [DIFF_W-1:0]  ramp_ext;
    logic signed [DIFF_W-1:0]  pick;
    logic                      under;
    logic                      over;
    logic [DAC_W-1:0]          dac_nxt;

    // Choose the operating mode and form the signed candidate value.
    always_comb begin
        mode     = en ? OUT_COMP : OUT_BYPASS;
        sp_ext   = signed'({{(DIFF_W - SP_W){1'b0}}, sp});
        ramp_ext = signed'({{(DIFF_W - RAMP_W){1'b0}}, ramp});
        pick     = (mode == OUT_COMP) ? (sp_ext - ramp_ext) : sp_ext;
        under    = pick[DIFF_W-1];
    end

    // The upper clamp exists only when the set point can exceed the DAC range.
    generate
        if (SP_W > DAC_W) begin : g_hi_clamp
            always_comb over = (pick > DAC_TOP);
        end else begin : g_no_hi_clamp
            always_comb over = 1'b0;
        end
    endgenerate

    // Saturate to the DAC range.
    always_comb begin
        if (under) begin
            dac_nxt = '0;
        end else if (over) begin
            dac_nxt = '1;
        end else begin
            dac_nxt = pick[DAC_W-1:0];
        end
    end

    // Register the code so the DAC sees a clean, glitch-free word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac <= '0;
        end else begin
            dac <= dac_nxt;
        end
    end

endmodule

// File: rtl/slope_ref_gen.sv
// Top: slope-compensated peak-current threshold generator.
// Captures set point and slope on the PWM period strobe, runs a per-period
// ramp and drives a clamped DAC code. Assumes period_start is one clock wide.
module slope_ref_gen #(
    parameter int SP_W  = 12,
    parameter int DAC_W = 10,
    parameter int SL_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             period_start,
    input  logic [SP_W-1:0]  set_point,
    input  logic [SL_W-1:0]  slope,
    output logic [DAC_W-1:0] dac_code
);

    localparam int RAMP_W = SP_W + 1;

    logic [SP_W-1:0]   sp_act;
    logic [SL_W-1:0]   slope_act;
    logic [RAMP_W-1:0] ramp_val;

    sr_shadow_reg #(.W(SP_W)) u_sp_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (period_start),
        .d     (set_point),
        .q     (sp_act)
    );

    sr_shadow_reg #(.W(SL_W)) u_slope_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (period_start),
        .d     (slope),
        .q     (slope_act)
    );

    sr_ramp_acc #(.SL_W(SL_W), .RAMP_W(RAMP_W)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (period_start),
        .step    (slope_act),
        .ramp    (ramp_val)
    );

    sr_out_stage #(.SP_W(SP_W), .RAMP_W(RAMP_W), .DAC_W(DAC_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .sp    (sp_act),
        .ramp  (ramp_val),
        .dac   (dac_code)
    );

endmodule

// File: rtl/slope_ref_chk.sv
// Checker for slope_ref_gen: timing of capture, restart, bypass and ramp.
// Assumes a single-clock period_start pulse.
module slope_ref_chk #(
    parameter int SP_W   = 12,
    parameter int DAC_W  = 10,
    parameter int SL_W   = 8,
    parameter int RAMP_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              period_start,
    input logic [DAC_W-1:0]  dac_code,
    input logic [SP_W-1:0]   sp_q,
    input logic [SL_W-1:0]   slope_q,
    input logic [RAMP_W-1:0] ramp_q
);

    // Clamp a set point into the DAC range.
    function automatic logic [DAC_W-1:0] lim(input logic [SP_W-1:0] v);
        logic [31:0] w;
        w = 32'(v);
        if (w > 32'((1 << DAC_W) - 1)) return '1;
        return w[DAC_W-1:0];
    endfunction

    // R2
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(sp_q));

    // R9
    slope_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(slope_q));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(period_start) && en) |=> (dac_code == lim($past(sp_q))));

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dac_code == lim($past(sp_q))));

    // R5
    flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slope_q == '0 && en) |=> (dac_code == lim($past(sp_q))));

    // R10
    ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> (ramp_q >= $past(ramp_q)));

endmodule

bind slope_ref_gen slope_ref_chk #(
    .SP_W(SP_W), .DAC_W(DAC_W), .SL_W(SL_W), .RAMP_W(RAMP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .period_start (period_start),
    .dac_code     (dac_code),
    .sp_q         (sp_act),
    .slope_q      (slope_act),
    .ramp_q       (ramp_val)
);

// File: tb/sim_slope_ref_gen.sv
// Bench for slope_ref_gen: vector table walk plus directed corner cases.
module sim_slope_ref_gen;

    localparam int SP_W  = 12;
    localparam int DAC_W = 10;
    localparam int SL_W  = 8;
    localparam int NVEC  = 11;

    // {set point, slope, edges after strobe, expected code}
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{ 500,  10,  1,  500},
        '{ 500,  10,  5,  460},
        '{ 500,   0, 20,  500},
        '{ 300,  50,  7,    0},
        '{ 300,  50, 10,    0},
        '{2000,   5,  3, 1023},
        '{1100,  20,  6, 1000},
        '{1023,   1,  1, 1023},
        '{4095, 255, 17,   15},
        '{4095, 255, 18,    0},
        '{  64,   3, 21,    4}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic             period_start;
    logic [SP_W-1:0]  set_point;
    logic [SL_W-1:0]  slope;
    logic [DAC_W-1:0] dac_code;

    int n_cmp  = 0;
    int n_bad  = 0;

    always #10 clk = ~clk;

    slope_ref_gen #(.SP_W(SP_W), .DAC_W(DAC_W), .SL_W(SL_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .period_start (period_start),
        .set_point    (set_point),
        .slope        (slope),
        .dac_code     (dac_code)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Called at a falling edge: strobe, then wait n more rising edges.
    task automatic run_period(input int s, input int m, input int n,
                              input int exp, input string tag);
        set_point    = SP_W'(s);
        slope        = SL_W'(m);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        repeat (n) @(negedge clk);
        check(tag, int'(dac_code), exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b1; period_start = 1'b0;
        set_point = '0; slope = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", int'(dac_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", int'(dac_code), 0);

        // Table walk: R4 ramp arithmetic, clamps and timing
        for (int i = 0; i < NVEC; i++) begin
            run_period(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], "R4 table");
        end

        // R5 zero slope keeps the set point
        run_period(500, 0, 20, 500, "R5");
        // R6 floor at zero
        run_period(300, 50, 10, 0, "R6");
        // R7 ceiling at 1023
        run_period(2000, 5, 3, 1023, "R7");

        // R2 set point change mid-period is ignored until the strobe
        run_period(400, 0, 2, 400, "R2 start");
        set_point = SP_W'(900);
        repeat (3) @(negedge clk);
        check("R2 mid-period", int'(dac_code), 400);
        run_period(900, 0, 1, 900, "R2 next strobe");

        // R9 slope change mid-period is ignored
        run_period(600, 10, 1, 600, "R9 start");
        slope = SL_W'(100);
        repeat (4) @(negedge clk);
        check("R9 mid-period", int'(dac_code), 560);

        // R3 ramp restarts on the strobe
        run_period(200, 40, 10, 0, "R3 bottom");
        run_period(200, 40, 1, 200, "R3 restart");

        // R8 enable low passes the captured set point
        en = 1'b0;
        run_period(700, 40, 6, 700, "R8 bypass");
        run_period(3000, 40, 6, 1023, "R8 bypass clamp");
        en = 1'b1;

        // R10 ramp saturates; output stays 0 over a long period
        run_period(4095, 255, 18, 0, "R10 start");
        begin
            int bad = 0;
            int last = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (dac_code != '0) begin
                    bad++;
                    last = int'(dac_code);
                end
            end
            check("R10 long period", last + bad, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule